// File: doc/BRIEF.md
# Processor Execution Mode Controller

This block holds the privilege and addressing state of a processor core. At any time the core is in one of three execution states: slave (the normal running state for user code), master (privileged, but still addressing through the virtual path) or absolute (fully privileged, with instruction fetch confined to an 18-bit physical address). For each issued instruction the block judges whether it may run and whether its interrupt-inhibit request is honoured. It also tells the address hardware whether the instruction fetch and the operand fetch go through the appending (virtual) path or use a plain absolute address.

Any fault or interrupt entry drops the core into absolute mode. An illegal-procedure fault raised by the block itself does the same. The core stays in absolute mode until it executes a transfer whose operand address came from the appending path. On that transfer a target-privilege input, sampled along with it, picks whether execution resumes in master or in slave mode.

Top module: `exmode_ctrl`

## Requirements
- R1: A synchronous reset places the block in absolute mode. The mode output encodes slave as 2'b00, master as 2'b01 and absolute as 2'b10, and never shows 2'b11.
- R2: An issued privileged instruction in slave mode raises `illegal_o` and clears `exec_ok`. In master and absolute modes privileged instructions run with `exec_ok` high and `illegal_o` low.
- R3: The interrupt-inhibit request (instruction bit 28, input `inh_req`) on an issued instruction drives `inhibit_o` high in master and absolute modes. In slave mode it is ignored and `inhibit_o` stays low.
- R4: In slave and master modes both `ifetch_virt` and `opnd_virt` are 1 (appending path), whatever the value of bit 29.
- R5: In absolute mode `ifetch_virt` is 0, meaning fetch uses an 18-bit absolute address. In that mode `opnd_virt` equals instruction bit 29 (`ptr_sel`).
- R6: `trap_evt` high at a clock edge puts the block in absolute mode after that edge, from any mode. It takes priority over a simultaneous transfer.
- R7: In absolute mode, an issued transfer with bit 29 set moves the block to master if `tgt_master` is 1 and to slave if it is 0. A transfer with bit 29 clear, or any non-transfer, leaves the mode at absolute.
- R8: An illegal-procedure fault suppresses every mode update from that instruction. The block is in absolute mode after the next clock edge.
- R9: Transfers issued in slave or master mode that do not fault leave the mode unchanged.
- R10: With `issue` low, `illegal_o`, `inhibit_o` and `exec_ok` are all 0, and the mode does not change unless `trap_evt` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An instruction is presented this cycle |
| priv_op | input | 1 | Instruction is privileged |
| inh_req | input | 1 | Instruction bit 28: interrupt-inhibit request |
| ptr_sel | input | 1 | Instruction bit 29: operand via appending path |
| is_xfer | input | 1 | Instruction is a transfer |
| tgt_master | input | 1 | Privilege to resume in when leaving absolute mode (1 = master) |
| trap_evt | input | 1 | Fault or interrupt entry |
| mode_o | output | 2 | Current mode (00 slave, 01 master, 10 absolute) |
| illegal_o | output | 1 | Illegal-procedure fault for the current instruction |
| exec_ok | output | 1 | Current instruction may execute |
| inhibit_o | output | 1 | Effective interrupt inhibit |
| ifetch_virt | output | 1 | Instruction fetch through appending path |
| opnd_virt | output | 1 | Operand fetch through appending path |

## Verification
The hardest state to reach from the ports is a given mode paired with a given instruction. Slave and master can only be entered by leaving absolute mode through a transfer with bit 29 set, and a trap or fault drops the block straight back. For every combination, the bench therefore resets the block, steers it into the wanted mode with one such transfer, and then applies the instruction under test. Every combination of mode, privileged flag, bit 28, bit 29, transfer flag and target privilege is swept this way. Trap entry, including a trap that collides with a leaving transfer, and idle cycles are swept the same way.

// File: rtl/exmode_pkg.sv
package exmode_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_SLAVE  = 2'b00,
        MD_MASTER = 2'b01,
        MD_ABS    = 2'b10
    } exec_mode_t;

    typedef struct packed {
        logic issue;
        logic priv_op;
        logic inh_req;
        logic ptr_sel;
        logic is_xfer;
        logic tgt_master;
    } instr_ctl_t;

    typedef struct packed {
        logic illegal;
        logic exec_ok;
        logic inhibit;
    } perm_t;

    function automatic logic mode_privileged(exec_mode_t m);
        return (m != MD_SLAVE);
    endfunction

    function automatic logic mode_virtual_fetch(exec_mode_t m);
        return (m != MD_ABS);
    endfunction

endpackage

// File: rtl/exmode_perm.sv
module exmode_perm
    import exmode_pkg::*;
(
    input  exec_mode_t mode,
    input  instr_ctl_t ins,
    output perm_t      perm
);
    logic priv_ok;

    always_comb begin
        priv_ok      = mode_privileged(mode);
        perm.illegal = ins.issue & ins.priv_op & ~priv_ok;
        perm.exec_ok = ins.issue & ~perm.illegal;
        perm.inhibit = ins.issue & ins.inh_req & priv_ok;
    end
endmodule

// File: rtl/exmode_path.sv
module exmode_path
    import exmode_pkg::*;
(
    input  exec_mode_t mode,
    input  logic       ptr_sel,
    output logic       ifetch_virt,
    output logic       opnd_virt
);
    always_comb begin
        ifetch_virt = mode_virtual_fetch(mode);
        opnd_virt   = ifetch_virt ? 1'b1 : ptr_sel;
    end
endmodule

// File: rtl/exmode_state.sv
module exmode_state
    import exmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  instr_ctl_t ins,
    input  logic       trap_evt,
    input  logic       fault,
    input  logic       opnd_virt,
    output exec_mode_t mode
);
    exec_mode_t mode_nx;
    logic       leave_abs;

    always_comb begin
        leave_abs = (mode == MD_ABS) & ins.issue & ins.is_xfer & opnd_virt;
        mode_nx   = mode;
        if (trap_evt || fault) begin
            mode_nx = MD_ABS;
        end else if (leave_abs) begin
            mode_nx = ins.tgt_master ? MD_MASTER : MD_SLAVE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MD_ABS;
        end else begin
            mode <= mode_nx;
        end
    end
endmodule

// File: rtl/exmode_ctrl.sv
module exmode_ctrl
    import exmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  logic       priv_op,
    input  logic       inh_req,
    input  logic       ptr_sel,
    input  logic       is_xfer,
    input  logic       tgt_master,
    input  logic       trap_evt,
    output logic [1:0] mode_o,
    output logic       illegal_o,
    output logic       exec_ok,
    output logic       inhibit_o,
    output logic       ifetch_virt,
    output logic       opnd_virt
);
    exec_mode_t mode;
    instr_ctl_t ins;
    perm_t      perm;
    logic       opnd_v;

    always_comb begin
        ins.issue      = issue;
        ins.priv_op    = priv_op;
        ins.inh_req    = inh_req;
        ins.ptr_sel    = ptr_sel;
        ins.is_xfer    = is_xfer;
        ins.tgt_master = tgt_master;
    end

    exmode_perm u_perm (
        .mode (mode),
        .ins  (ins),
        .perm (perm)
    );

    exmode_path u_path (
        .mode        (mode),
        .ptr_sel     (ptr_sel),
        .ifetch_virt (ifetch_virt),
        .opnd_virt   (opnd_v)
    );

    exmode_state u_state (
        .clk       (clk),
        .rst       (rst),
        .ins       (ins),
        .trap_evt  (trap_evt),
        .fault     (perm.illegal),
        .opnd_virt (opnd_v),
        .mode      (mode)
    );

    assign mode_o    = mode;
    assign opnd_virt = opnd_v;
    assign illegal_o = perm.illegal;
    assign exec_ok   = perm.exec_ok;
    assign inhibit_o = perm.inhibit;
endmodule

// File: rtl/exmode_chk.sv
module exmode_chk (
    input logic       clk,
    input logic       rst,
    input logic       issue,
    input logic       ptr_sel,
    input logic       is_xfer,
    input logic       trap_evt,
    input logic [1:0] mode_o,
    input logic       illegal_o,
    input logic       exec_ok,
    input logic       inhibit_o,
    input logic       ifetch_virt,
    input logic       opnd_virt
);
    a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'b11);

    a_r2_fault_blocks_exec: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !exec_ok);

    a_r3_no_inhibit_in_slave: assert property (@(posedge clk) disable iff (rst)
        inhibit_o |-> (mode_o != 2'b00));

    a_r4_virtual_paths: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'b10) |-> (ifetch_virt && opnd_virt));

    a_r5_abs_fetch: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> (!ifetch_virt && (opnd_virt == ptr_sel)));

    a_r6_trap_enters_abs: assert property (@(posedge clk) disable iff (rst)
        trap_evt |=> (mode_o == 2'b10));

    a_r7_abs_sticky: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 2'b10) && !(issue && is_xfer && ptr_sel)) |=> (mode_o == 2'b10));

    a_r8_fault_enters_abs: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> (mode_o == 2'b10));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !issue |-> (!illegal_o && !exec_ok && !inhibit_o));
endmodule

bind exmode_ctrl exmode_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue       (issue),
    .ptr_sel     (ptr_sel),
    .is_xfer     (is_xfer),
    .trap_evt    (trap_evt),
    .mode_o      (mode_o),
    .illegal_o   (illegal_o),
    .exec_ok     (exec_ok),
    .inhibit_o   (inhibit_o),
    .ifetch_virt (ifetch_virt),
    .opnd_virt   (opnd_virt)
);

// File: tb/sim_exmode_ctrl.sv
module sim_exmode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] SLV = 2'b00;
    localparam logic [1:0] MST = 2'b01;
    localparam logic [1:0] ABS = 2'b10;

    logic clk = 1'b0;
    logic rst, issue, priv_op, inh_req, ptr_sel, is_xfer, tgt_master, trap_evt;
    logic [1:0] mode_o;
    logic illegal_o, exec_ok, inhibit_o, ifetch_virt, opnd_virt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exmode_ctrl u0 (
        .clk(clk), .rst(rst), .issue(issue), .priv_op(priv_op), .inh_req(inh_req),
        .ptr_sel(ptr_sel), .is_xfer(is_xfer), .tgt_master(tgt_master),
        .trap_evt(trap_evt), .mode_o(mode_o), .illegal_o(illegal_o),
        .exec_ok(exec_ok), .inhibit_o(inhibit_o), .ifetch_virt(ifetch_virt),
        .opnd_virt(opnd_virt)
    );

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        issue = 0; priv_op = 0; inh_req = 0; ptr_sel = 0;
        is_xfer = 0; tgt_master = 0; trap_evt = 0;
    endtask

    // inputs change 1 time unit after a rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // reset, then one leaving transfer if slave or master is wanted
    task automatic go_mode(logic [1:0] m);
        idle_inputs();
        rst = 1;
        step();
        rst = 0;
        if (m != ABS) begin
            issue = 1; is_xfer = 1; ptr_sel = 1; tgt_master = (m == MST);
            step();
            idle_inputs();
        end
        chk("R7 setup", mode_o, m);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        step();
        step();
        rst = 0;
        #1;
        chk("R1 reset mode", mode_o, ABS);
        chk("R10 reset idle illegal", {1'b0, illegal_o}, 2'd0);
        chk("R10 reset idle exec", {1'b0, exec_ok}, 2'd0);

        // full sweep: mode x priv x bit28 x bit29 x transfer x target
        for (int m = 0; m < 3; m++) begin
            for (int v = 0; v < 32; v++) begin
                logic [1:0] md, nx;
                logic p, b28, b29, x, t, ill, inh, ifv, opv;
                md = m[1:0];
                {p, b28, b29, x, t} = v[4:0];
                go_mode(md);
                issue = 1; priv_op = p; inh_req = b28; ptr_sel = b29;
                is_xfer = x; tgt_master = t;
                #1;
                ill = p && (md == SLV);
                inh = b28 && (md != SLV);
                ifv = (md != ABS);
                opv = (md != ABS) ? 1'b1 : b29;
                if (ill) nx = ABS;
                else if (md == ABS && x && b29) nx = t ? MST : SLV;
                else nx = md;
                chk("R2 illegal", {1'b0, illegal_o}, {1'b0, ill});
                chk("R2 exec_ok", {1'b0, exec_ok}, {1'b0, !ill});
                chk("R3 inhibit", {1'b0, inhibit_o}, {1'b0, inh});
                chk(md == ABS ? "R5 ifetch" : "R4 ifetch", {1'b0, ifetch_virt}, {1'b0, ifv});
                chk(md == ABS ? "R5 operand" : "R4 operand", {1'b0, opnd_virt}, {1'b0, opv});
                step();
                idle_inputs();
                if (ill) chk("R8 fault next mode", mode_o, nx);
                else if (md == ABS) chk("R7 next mode", mode_o, nx);
                else chk("R9 next mode", mode_o, nx);
            end
        end

        // trap entry, with and without a colliding leaving transfer
        for (int m = 0; m < 3; m++) begin
            for (int c = 0; c < 2; c++) begin
                go_mode(m[1:0]);
                trap_evt = 1;
                if (c == 1) begin
                    issue = 1; is_xfer = 1; ptr_sel = 1; tgt_master = 1;
                end
                step();
                idle_inputs();
                chk("R6 trap to absolute", mode_o, ABS);
            end
        end

        // idle cycles: no outputs, no mode change
        for (int m = 0; m < 3; m++) begin
            go_mode(m[1:0]);
            priv_op = 1; inh_req = 1; is_xfer = 1; ptr_sel = 1; tgt_master = 1;
            #1;
            chk("R10 idle illegal", {1'b0, illegal_o}, 2'd0);
            chk("R10 idle inhibit", {1'b0, inhibit_o}, 2'd0);
            chk("R10 idle exec", {1'b0, exec_ok}, 2'd0);
            step();
            chk("R10 idle mode hold", mode_o, m[1:0]);
            idle_inputs();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule